// File: doc/BRIEF.md
# Exclusive Two-Level Cache Controller

This block is a two-level cache hierarchy that never keeps the same line in both levels. A processor issues one word-sized read or write at a time. The block looks the address up in a small first level first. Only if the first level misses is the larger second level consulted. A line found in the second level trades places with the oldest first-level line in its set. A line that neither level holds is fetched from backing memory into the first level. The first-level line it displaces drops into the second level.

Both levels share the same set index, so a demoted line always lands in the set its address selects. The first level has 2 ways per set and the second level has 16. Lines are 64 bytes. Age is tracked per way as true LRU, and an invalid way is always chosen as a victim before a valid one. A line leaves the hierarchy only when a first-level victim has to enter a full second-level set. The oldest second-level line is then retired, and it is written to memory only if it was modified while cached. Stores never produce memory traffic by themselves.

Top module: `xc_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0, and every line of both levels is invalid and clean, so the first access to any address fetches from memory.
- R2: A request whose line is in the first level is answered with one `rsp_valid` pulse carrying the addressed word, and raises no `mem_req`.
- R3: A request that misses the first level but hits the second level moves the line into the first level and moves the oldest first-level line of that set into the freed second-level way, all without any memory access.
- R4: A request that misses both levels issues exactly one memory read (`mem_we`=0). The read uses the 64-byte aligned line address (`mem_addr` bits 5:0 are zero). The request is answered from the returned line, in which word i occupies bits 32*i+31:32*i and is selected by request address bits 5:2.
- R5: No line address is valid in both levels at once. Taken together, the two levels hold 18 distinct lines per set, and each can be re-read with no memory access.
- R6: When a displaced first-level line must enter a full second-level set, the least recently used second-level line is retired. It is written to memory (`mem_we`=1, line address) only if dirty, and dropped silently if clean.
- R7: A store only updates the cached line and marks it dirty. Its data reaches memory in the write-back that happens when the line is retired. The dirty mark moves with the line between levels.
- R8: Within each level, the victim is an invalid way if one exists, and otherwise the way used or inserted least recently.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle of its single-cycle `rsp_valid` pulse.
- R10: Once `mem_req` is raised, it and `mem_we`, `mem_addr` and `mem_wdata` hold steady until the cycle `mem_ack` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the word |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | WORD_W | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | WORD_W | Word read (or the word just stored) |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = line fetch |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | LINE_BYTES*8 | Line being written back |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | LINE_BYTES*8 | Fetched line, valid with mem_ack |

## Verification
Two moves share one clock edge. On a second-level hit, the promotion of the hit line into the first level coincides with the demotion of the first-level victim into the very second-level way being vacated. On fill completion, the install of the fetched line coincides with the victim's demotion into the chosen second-level slot. The bench provokes both by filling one set with eighteen lines, re-reading a line held only in the second level, and then pushing new lines into the full set. It judges the outcome through the returned data against a flat reference memory, through counts of memory reads and writes, and through the address and content of the dirty line that gets written back.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_WB   = 2'd2,
    S_FILL = 2'd3
  } xc_state_t;
endpackage

// File: rtl/xc_level.sv
module xc_level #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 24,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [WAYS-1:0]   valid_vec_o,
  input  logic [WAY_W-1:0]  rd_way_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [LINE_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic [LINE_W-1:0] wr_data_i
);
  localparam int ENTRIES = SETS * WAYS;

  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [LINE_W-1:0] data_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [WAYS-1:0]    hit_vec;

  function automatic int slot(input logic [IDX_W-1:0] s, input logic [WAY_W-1:0] w);
    return int'(s) * WAYS + int'(w);
  endfunction

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign valid_vec_o[w] = valid_q[int'(set_i) * WAYS + w];
      assign hit_vec[w] = valid_vec_o[w] && (tag_q[int'(set_i) * WAYS + w] == tag_i);
    end
  endgenerate

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end
  assign hit_o = |hit_vec;

  assign rd_tag_o   = tag_q[slot(set_i, rd_way_i)];
  assign rd_valid_o = valid_q[slot(set_i, rd_way_i)];
  assign rd_dirty_o = dirty_q[slot(set_i, rd_way_i)];
  assign rd_data_o  = data_q[slot(set_i, rd_way_i)];

  // Line storage: no reset, single write port (RAM-inferable).
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      data_q[slot(set_i, wr_way_i)] <= wr_data_i;
      tag_q[slot(set_i, wr_way_i)]  <= wr_tag_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[slot(set_i, wr_way_i)] <= wr_valid_i;
      dirty_q[slot(set_i, wr_way_i)] <= wr_valid_i && wr_dirty_i;
    end
  end

  // R5: a tag never matches in two ways of one set
  a_r5_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
  // R1: a dirty bit exists only beside a valid bit
  a_r1_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rd_dirty_o |-> rd_valid_o);
endmodule

// File: rtl/xc_age_lru.sv
module xc_age_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_vec_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             touch_en_i,
  input  logic [WAY_W-1:0] touch_way_i
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  // Ages in a set form a permutation; 0 is youngest, WAYS-1 oldest.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_vec_i[w]) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
  end

  // R8: a touched way is never the next victim of a full set
  a_r8_touch_not_victim: assert property (@(posedge clk) disable iff (rst)
    touch_en_i && (&valid_vec_i) && $stable(set_i) ##1 (&valid_vec_i) && $stable(set_i)
    |-> victim_o != $past(touch_way_i));
endmodule

// File: rtl/xc_cache.sv
module xc_cache
  import xc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int L1_WAYS    = 2,
  parameter int L2_WAYS    = 16,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WSEL_W = $clog2(LINE_W / WORD_W);
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int W1     = $clog2(L1_WAYS);
  localparam int W2     = $clog2(L2_WAYS);

  xc_state_t state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [W1-1:0]     l1v_q;
  logic [W2-1:0]     l2v_q;

  logic [IDX_W-1:0]  set;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  assign set  = addr_q[OFF_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel = addr_q[BSEL_W +: WSEL_W];

  // Level 1 signals
  logic l1_hit, l1_rd_valid, l1_rd_dirty, l1_wr_en, l1_wr_dirty, l1_touch;
  logic [W1-1:0] l1_hit_way, l1_rd_way, l1_vict, l1_wr_way, l1_touch_way;
  logic [L1_WAYS-1:0] l1_vv;
  logic [TAG_W-1:0] l1_rd_tag;
  logic [LINE_W-1:0] l1_rd_data, l1_wr_data;
  // Level 2 signals
  logic l2_hit, l2_rd_valid, l2_rd_dirty, l2_wr_en, l2_wr_valid, l2_wr_dirty, l2_touch;
  logic [W2-1:0] l2_hit_way, l2_rd_way, l2_vict, l2_wr_way, l2_touch_way;
  logic [L2_WAYS-1:0] l2_vv;
  logic [TAG_W-1:0] l2_rd_tag, l2_wr_tag;
  logic [LINE_W-1:0] l2_rd_data, l2_wr_data;

  logic [LINE_W-1:0] src_line, merged;
  logic              finish;

  xc_level #(.SETS(SETS), .WAYS(L1_WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_l1 (
    .clk(clk), .rst(rst), .set_i(set), .tag_i(tag),
    .hit_o(l1_hit), .hit_way_o(l1_hit_way), .valid_vec_o(l1_vv),
    .rd_way_i(l1_rd_way), .rd_tag_o(l1_rd_tag), .rd_valid_o(l1_rd_valid),
    .rd_dirty_o(l1_rd_dirty), .rd_data_o(l1_rd_data),
    .wr_en_i(l1_wr_en), .wr_way_i(l1_wr_way), .wr_tag_i(tag), .wr_valid_i(1'b1),
    .wr_dirty_i(l1_wr_dirty), .wr_data_i(l1_wr_data));

  xc_level #(.SETS(SETS), .WAYS(L2_WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_l2 (
    .clk(clk), .rst(rst), .set_i(set), .tag_i(tag),
    .hit_o(l2_hit), .hit_way_o(l2_hit_way), .valid_vec_o(l2_vv),
    .rd_way_i(l2_rd_way), .rd_tag_o(l2_rd_tag), .rd_valid_o(l2_rd_valid),
    .rd_dirty_o(l2_rd_dirty), .rd_data_o(l2_rd_data),
    .wr_en_i(l2_wr_en), .wr_way_i(l2_wr_way), .wr_tag_i(l2_wr_tag), .wr_valid_i(l2_wr_valid),
    .wr_dirty_i(l2_wr_dirty), .wr_data_i(l2_wr_data));

  xc_age_lru #(.SETS(SETS), .WAYS(L1_WAYS)) u_age1 (
    .clk(clk), .rst(rst), .set_i(set), .valid_vec_i(l1_vv), .victim_o(l1_vict),
    .touch_en_i(l1_touch), .touch_way_i(l1_touch_way));

  xc_age_lru #(.SETS(SETS), .WAYS(L2_WAYS)) u_age2 (
    .clk(clk), .rst(rst), .set_i(set), .valid_vec_i(l2_vv), .victim_o(l2_vict),
    .touch_en_i(l2_touch), .touch_way_i(l2_touch_way));

  // Way selection for the read side of each level
  always_comb begin
    if (state_q == S_LOOK) begin
      l1_rd_way = l1_hit ? l1_hit_way : l1_vict;
      l2_rd_way = l2_hit ? l2_hit_way : l2_vict;
    end else begin
      l1_rd_way = l1v_q;
      l2_rd_way = l2v_q;
    end
  end

  // Line that supplies the requested word, with a pending store merged in
  always_comb begin
    if (state_q == S_FILL)  src_line = mem_rdata;
    else if (l1_hit)        src_line = l1_rd_data;
    else                    src_line = l2_rd_data;
    merged = src_line;
    if (we_q) merged[int'(wsel) * WORD_W +: WORD_W] = wdata_q;
  end

  // Level updates: promotion, demotion, fill, store
  always_comb begin
    l1_wr_en = 1'b0; l1_wr_way = l1_vict; l1_wr_dirty = we_q; l1_wr_data = merged;
    l1_touch = 1'b0; l1_touch_way = l1_vict;
    l2_wr_en = 1'b0; l2_wr_way = l2_hit_way; l2_wr_tag = l1_rd_tag;
    l2_wr_valid = l1_rd_valid; l2_wr_dirty = l1_rd_dirty; l2_wr_data = l1_rd_data;
    l2_touch = 1'b0; l2_touch_way = l2_hit_way;
    finish = 1'b0;
    unique case (state_q)
      S_LOOK: begin
        if (l1_hit) begin
          finish       = 1'b1;
          l1_wr_en     = we_q;
          l1_wr_way    = l1_hit_way;
          l1_wr_dirty  = 1'b1;
          l1_touch     = 1'b1;
          l1_touch_way = l1_hit_way;
        end else if (l2_hit) begin
          finish      = 1'b1;
          l1_wr_en    = 1'b1;
          l1_wr_dirty = l2_rd_dirty | we_q;
          l1_touch    = 1'b1;
          l2_wr_en    = 1'b1;
          l2_touch    = l1_rd_valid;
        end
      end
      S_FILL: begin
        if (mem_ack) begin
          finish       = 1'b1;
          l1_wr_en     = 1'b1;
          l1_wr_way    = l1v_q;
          l1_touch     = 1'b1;
          l1_touch_way = l1v_q;
          l2_wr_en     = l1_rd_valid;
          l2_wr_way    = l2v_q;
          l2_touch     = l1_rd_valid;
          l2_touch_way = l2v_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      l1v_q     <= '0;
      l2v_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= finish;
      if (finish) begin
        rsp_rdata <= merged[int'(wsel) * WORD_W +: WORD_W];
        state_q   <= S_IDLE;
      end
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          we_q    <= req_we;
          wdata_q <= req_wdata;
          state_q <= S_LOOK;
        end
        S_LOOK: if (!l1_hit && !l2_hit) begin
          l1v_q   <= l1_vict;
          l2v_q   <= l2_vict;
          state_q <= (l1_rd_valid && l2_rd_valid && l2_rd_dirty) ? S_WB : S_FILL;
        end
        S_WB:   if (mem_ack) state_q <= S_FILL;
        default: ;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign mem_req   = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = (state_q == S_WB) ? {l2_rd_tag, set, {OFF_W{1'b0}}}
                                       : {tag, set, {OFF_W{1'b0}}};
  assign mem_wdata = l2_rd_data;

  // R5: a looked-up line is never resident in both levels
  a_r5_no_dual_residency: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_LOOK) |-> !(l1_hit && l2_hit));
  // R6: a write-back only carries a valid dirty second-level line
  a_r6_wb_only_dirty: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WB) |-> (l2_rd_valid && l2_rd_dirty));
  // R9: the response is a single-cycle pulse
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R9: acceptance drops ready on the next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R10: a memory request holds until acknowledged
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                && $stable(mem_wdata)));
endmodule

// File: tb/xc_cache_test.sv
module xc_cache_test;
  localparam int ADDR_W = 32, WORD_W = 32, LINE_W = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [WORD_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [LINE_W-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  xc_cache uut (.*);

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, issued = 0, seen = 0;
  logic [ADDR_W-1:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [WORD_W-1:0] ref_mem [int unsigned];
  logic [LINE_W-1:0] back_mem [int unsigned];
  logic [WORD_W-1:0] exp_q [$];
  string tag_q [$];

  function automatic logic [WORD_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [LINE_W-1:0] pat_line(input logic [ADDR_W-1:0] base);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = pat(base + ADDR_W'(4 * i));
    return l;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Backing memory: answers each request two cycles after seeing it
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        repeat (2) @(negedge clk);
        if (mem_we) begin
          back_mem[mem_addr >> 6] = mem_wdata;
          wr_cnt++;
          last_wr_addr = mem_addr;
        end else begin
          mem_rdata = back_mem.exists(mem_addr >> 6) ? back_mem[mem_addr >> 6]
                                                     : pat_line(mem_addr);
          rd_cnt++;
          last_rd_addr = mem_addr;
        end
        mem_ack = 1'b1;
      end
    end
  end

  // Monitor: pops the scoreboard on each response
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk("R9 unexpected response", 64'(rsp_rdata), 64'hX);
        else chk(tag_q.pop_front(), 64'(rsp_rdata), 64'(exp_q.pop_front()));
        seen++;
      end
    end
  end

  // Driver: issues one access and queues its expected word
  task automatic access(input string req, input logic [ADDR_W-1:0] a,
                        input logic we, input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] e;
    while (!req_ready) @(negedge clk);
    if (we) begin
      ref_mem[a >> 2] = d;
      e = d;
    end else e = ref_mem.exists(a >> 2) ? ref_mem[a >> 2] : pat(a);
    exp_q.push_back(e);
    tag_q.push_back(req);
    issued++;
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) chk("R9 ready low while busy", 64'(req_ready), 64'd0);
    while (seen < issued) @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] ln(input int k);
    return ADDR_W'(k * 256);   // every line k falls in set 0
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 no response after reset", 64'(rsp_valid), 64'd0);
    chk("R1 no memory request after reset", 64'(mem_req), 64'd0);

    access("R1 R4 cold miss read", ln(0) + 32'h8, 1'b0, '0);
    chk("R4 one fetch", 64'(rd_cnt), 64'd1);
    chk("R4 aligned fetch address", 64'(last_rd_addr), 64'(ln(0)));

    access("R2 first-level hit", ln(0) + 32'h8, 1'b0, '0);
    chk("R2 no memory on hit", 64'(rd_cnt), 64'd1);

    access("R7 store to cached line", ln(0) + 32'hC, 1'b1, 32'hDEAD_BEEF);
    chk("R7 store makes no write-back", 64'(wr_cnt), 64'd0);

    for (int k = 1; k <= 17; k++) access("R4 fill set", ln(k) + 32'h34, 1'b0, '0);
    chk("R4 R5 eighteen fetches", 64'(rd_cnt), 64'd18);
    chk("R4 aligned fetch address unaligned req", 64'(last_rd_addr), 64'(ln(17)));

    access("R3 second-level hit data", ln(5) + 32'h4, 1'b0, '0);
    chk("R3 swap without memory", 64'(rd_cnt + wr_cnt), 64'd18);

    access("R5 re-read demoted line", ln(16), 1'b0, '0);
    access("R5 re-read old line", ln(2), 1'b0, '0);
    chk("R5 eighteen lines held", 64'(rd_cnt + wr_cnt), 64'd18);

    // State now: L1 {L16? no} -- recomputed: L1 holds L2,L16; L2 oldest is L0 (dirty)
    access("R6 miss into full set", ln(18), 1'b0, '0);
    chk("R6 dirty retire written back", 64'(wr_cnt), 64'd1);
    chk("R6 write-back address", 64'(last_wr_addr), 64'(ln(0)));
    chk("R7 write-back carries store", 64'(back_mem[ln(0) >> 6][3*32 +: 32]), 64'hDEAD_BEEF);

    access("R6 clean retire", ln(19), 1'b0, '0);
    chk("R6 clean line dropped silently", 64'(wr_cnt), 64'd1);
    chk("R6 fetch count", 64'(rd_cnt), 64'd20);

    access("R7 retired dirty line refetched", ln(0) + 32'hC, 1'b0, '0);
    chk("R7 refetch count", 64'(rd_cnt), 64'd21);

    // L1 holds L19,L0; touching L19 makes L0 the victim
    access("R8 touch", ln(19), 1'b0, '0);
    access("R8 new line", ln(20), 1'b0, '0);
    access("R8 recently used kept", ln(19) + 32'h10, 1'b0, '0);
    chk("R8 L1 victim was the older way", 64'(rd_cnt), 64'd22);
    access("R7 dirty mark travels", ln(0) + 32'hC, 1'b0, '0);
    chk("R7 demoted line found below", 64'(rd_cnt + wr_cnt), 64'd23);

    access("R4 write-allocate other set", 32'h0000_0048, 1'b1, 32'h1234_5678);
    access("R2 read back other set", 32'h0000_0048, 1'b0, '0);
    chk("R4 write-allocate fetch", 64'(rd_cnt), 64'd23);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule